// File: doc/BRIEF.md
# Load-Store Lane Unit for Sub-Word Accesses

This unit connects a 32-bit core to a byte-addressed data memory that is one word wide and stores bytes big-endian, so the most significant byte of a word sits at the word's own address. It is purely combinational and sits on the memory side of the load-store path. It takes the two low address bits, an access size and a sign flag.

On a load it picks the addressed byte or halfword out of the word read from memory. It right-justifies the value and extends it to 32 bits, using sign extension or zero extension as the flag selects.

On a store it moves the low byte or halfword of the source register into the addressed lane, clears every other lane and raises one write enable per written lane. An access that is not naturally aligned, or that uses the reserved size code, raises a fault output. A fault silences every data and enable output, so the memory sees no write.

Top module: `lsu_lane_unit`

## Requirements
- R1: Size code 00 selects a byte access. For address offset o, a load returns readWord bits [31-8o : 24-8o], so offset 0 returns bits [31:24] and offset 3 returns bits [7:0].
- R2: Size code 01 selects a halfword and size code 10 selects a word. A halfword load at offset 0 returns bits [31:16] and one at offset 2 returns bits [15:0]. A word load at offset 0 returns the whole word, whatever the sign flag is.
- R3: With isSigned = 1, a byte or halfword load copies the top bit of the selected value into every higher bit of loadData.
- R4: With isSigned = 0, a byte or halfword load clears every bit of loadData above the selected value.
- R5: A byte store places storeData[7:0] in the addressed lane and drives zero in the other three lanes. It raises exactly one enable: byteEn bit 3 covers bits [31:24] and bit 0 covers bits [7:0], so offset 0 gives 1000 and offset 3 gives 0001.
- R6: A halfword store places storeData[15:0] in bits [31:16] with byteEn 1100 at offset 0, or in bits [15:0] with byteEn 0011 at offset 2. The other half of writeData is zero.
- R7: A word store at offset 0 passes storeData through unchanged with byteEn 1111.
- R8: A halfword at an odd offset, or a word at a nonzero offset, raises misalign. It also drives byteEn, loadData and writeData to zero.
- R9: Size code 11 is reserved. At any offset it raises misalign and drives byteEn, loadData and writeData to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addrLow | input | 2 | Low two bits of the byte address |
| accSize | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| isSigned | input | 1 | 1 selects sign extension for a sub-word load |
| readWord | input | 32 | Word read from the data memory |
| storeData | input | 32 | Source register value for a store |
| loadData | output | 32 | Extended load result |
| writeData | output | 32 | Lane-positioned store word |
| byteEn | output | 4 | Per-lane write enable, bit 3 covers bits [31:24] |
| misalign | output | 1 | Unaligned access or reserved size code |

## Verification
The hardest case is a store whose source register carries nonzero bits above the byte or halfword being stored. A correct design shifts those bits out of every enabled lane. The mirror case on the load side is a signed load whose top bit is set, against an unsigned load of the same lane. The stimulus therefore uses a read word in which every lane differs and several lanes have their top bit set. It pairs that with a store value whose upper bytes are all nonzero, and sweeps every offset and size against both values of the sign flag. Directed cases then step the sign bit across its boundary (7F against 80, 7FFF against 8000) and exercise each unaligned pattern.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  parameter int LANE_W = 8;
  parameter int LANES  = 4;
  localparam int OFS_W  = $clog2(LANES);
  localparam int DATA_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // strobes passed from the control decode to the datapath
  typedef struct packed {
    logic             fault;
    logic             extSign;
    logic [OFS_W:0]   spanOneHot;  // bit k: access covers 2**k lanes
    logic [OFS_W-1:0] shiftLanes;  // lanes between access and bit 0
    logic [LANES-1:0] laneEn;
  } lane_ctrl_t;
endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lsu_lane_pkg::*;
#(
  parameter int NLANES = LANES,
  localparam int OW = $clog2(NLANES)
) (
  input  logic [OW-1:0] addrLow,
  input  logic [1:0]    accSize,
  input  logic          isSigned,
  output lane_ctrl_t    ctrl
);
  int  spanLanes;
  int  shiftAmt;
  logic sizeOk;
  logic aligned;

  always_comb begin
    sizeOk    = (int'(accSize) <= OW);
    spanLanes = sizeOk ? (1 << int'(accSize)) : NLANES;
    aligned   = ((int'(addrLow) & (spanLanes - 1)) == 0);
    shiftAmt  = NLANES - spanLanes - int'(addrLow);
    if (shiftAmt < 0) shiftAmt = 0;

    ctrl.fault      = !(sizeOk && aligned);
    ctrl.extSign    = isSigned;
    ctrl.shiftLanes = OW'(shiftAmt);
    for (int k = 0; k <= OW; k++) begin
      ctrl.spanOneHot[k] = !ctrl.fault && (int'(accSize) == k);
    end
    for (int l = 0; l < NLANES; l++) begin
      ctrl.laneEn[l] = !ctrl.fault && (l >= shiftAmt) && (l < shiftAmt + spanLanes);
    end
  end
endmodule

// File: rtl/lane_datapath.sv
module lane_datapath
  import lsu_lane_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int NLANES = LANES,
  localparam int DW = LW * NLANES,
  localparam int OW = $clog2(NLANES)
) (
  input  lane_ctrl_t     ctrl,
  input  logic [DW-1:0]  readWord,
  input  logic [DW-1:0]  storeData,
  output logic [DW-1:0]  loadData,
  output logic [DW-1:0]  writeData
);
  logic [DW-1:0] rightJust;
  logic [DW-1:0] leftPlaced;
  logic [DW-1:0] cand [OW+1];

  assign rightJust  = readWord  >> (LW * int'(ctrl.shiftLanes));
  assign leftPlaced = storeData << (LW * int'(ctrl.shiftLanes));

  // one extension candidate per access width
  for (genvar k = 0; k <= OW; k++) begin : g_ext
    localparam int W = LW << k;
    if (W >= DW) begin : g_full
      assign cand[k] = rightJust;
    end else begin : g_part
      assign cand[k] = {{(DW - W){ctrl.extSign & rightJust[W-1]}}, rightJust[W-1:0]};
    end
  end

  always_comb begin
    loadData = '0;
    for (int k = 0; k <= OW; k++) begin
      if (ctrl.spanOneHot[k]) loadData = loadData | cand[k];
    end
  end

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    assign writeData[l*LW +: LW] = ctrl.laneEn[l] ? leftPlaced[l*LW +: LW] : '0;
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
(
  input  logic [1:0]  addrLow,
  input  logic [1:0]  accSize,
  input  logic        isSigned,
  input  logic [31:0] readWord,
  input  logic [31:0] storeData,
  output logic [31:0] loadData,
  output logic [31:0] writeData,
  output logic [3:0]  byteEn,
  output logic        misalign
);
  lane_ctrl_t ctrl;

  lane_ctrl #(.NLANES(4)) u_ctrl (
    .addrLow (addrLow),
    .accSize (accSize),
    .isSigned(isSigned),
    .ctrl    (ctrl)
  );

  lane_datapath #(.LW(8), .NLANES(4)) u_dp (
    .ctrl     (ctrl),
    .readWord (readWord),
    .storeData(storeData),
    .loadData (loadData),
    .writeData(writeData)
  );

  assign byteEn   = ctrl.laneEn;
  assign misalign = ctrl.fault;

  always_comb begin
    if (misalign) begin
      p_fault_quiet_r8: assert (byteEn == 4'b0 && loadData == 32'b0 && writeData == 32'b0)
        else $error("fault with live outputs");
    end
    if (!misalign && accSize == SZ_BYTE) begin
      p_byte_one_lane_r5: assert ($countones(byteEn) == 1)
        else $error("byte access enables wrong lane count");
    end
    if (!misalign && accSize == SZ_HALF) begin
      p_half_two_lanes_r6: assert ($countones(byteEn) == 2)
        else $error("halfword access enables wrong lane count");
    end
    if (!misalign && accSize == SZ_WORD) begin
      p_word_all_lanes_r7: assert (byteEn == 4'b1111)
        else $error("word access misses a lane");
    end
    if (!misalign && accSize == SZ_BYTE && !isSigned) begin
      p_zero_ext_r4: assert (loadData[31:8] == 24'b0)
        else $error("unsigned byte not zero-extended");
    end
    if (!misalign && accSize == SZ_BYTE && isSigned) begin
      p_sign_ext_r3: assert (loadData[31:8] == {24{loadData[7]}})
        else $error("signed byte not sign-extended");
    end
    if (!misalign && accSize == SZ_RSVD) begin
      p_rsvd_fault_r9: assert (1'b0) else $error("reserved size accepted");
    end
  end
endmodule

// File: tb/tb_lsu_lane_unit.sv
module tb_lsu_lane_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  addrLow = '0;
  logic [1:0]  accSize = '0;
  logic        isSigned = 1'b0;
  logic [31:0] readWord = '0;
  logic [31:0] storeData = '0;
  logic [31:0] loadData, writeData;
  logic [3:0]  byteEn;
  logic        misalign;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  lsu_lane_unit dut (
    .addrLow(addrLow), .accSize(accSize), .isSigned(isSigned),
    .readWord(readWord), .storeData(storeData),
    .loadData(loadData), .writeData(writeData),
    .byteEn(byteEn), .misalign(misalign)
  );

  typedef struct packed {
    logic [1:0]  a;
    logic [1:0]  s;
    logic        g;
    logic [31:0] el;
    logic [31:0] ew;
    logic [3:0]  eb;
    logic        ee;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] RW = 32'h8A3C_F105;
  localparam logic [31:0] SD = 32'h1234_96E7;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b1, 32'hFFFF_FF8A, 32'hE700_0000, 4'b1000, 1'b0, 4'd3}, // R3 R1 R5
    '{2'd0, 2'd0, 1'b0, 32'h0000_008A, 32'hE700_0000, 4'b1000, 1'b0, 4'd4}, // R4
    '{2'd1, 2'd0, 1'b1, 32'h0000_003C, 32'h00E7_0000, 4'b0100, 1'b0, 4'd1}, // R1
    '{2'd2, 2'd0, 1'b1, 32'hFFFF_FFF1, 32'h0000_E700, 4'b0010, 1'b0, 4'd3}, // R3
    '{2'd3, 2'd0, 1'b0, 32'h0000_0005, 32'h0000_00E7, 4'b0001, 1'b0, 4'd5}, // R5
    '{2'd2, 2'd0, 1'b0, 32'h0000_00F1, 32'h0000_E700, 4'b0010, 1'b0, 4'd4}, // R4
    '{2'd0, 2'd1, 1'b1, 32'hFFFF_8A3C, 32'h96E7_0000, 4'b1100, 1'b0, 4'd6}, // R6 R2
    '{2'd0, 2'd1, 1'b0, 32'h0000_8A3C, 32'h96E7_0000, 4'b1100, 1'b0, 4'd2}, // R2
    '{2'd2, 2'd1, 1'b1, 32'hFFFF_F105, 32'h0000_96E7, 4'b0011, 1'b0, 4'd6}, // R6
    '{2'd2, 2'd1, 1'b0, 32'h0000_F105, 32'h0000_96E7, 4'b0011, 1'b0, 4'd2}, // R2
    '{2'd0, 2'd2, 1'b1, 32'h8A3C_F105, 32'h1234_96E7, 4'b1111, 1'b0, 4'd7}, // R7
    '{2'd0, 2'd2, 1'b0, 32'h8A3C_F105, 32'h1234_96E7, 4'b1111, 1'b0, 4'd2}, // R2
    '{2'd1, 2'd1, 1'b1, 32'h0,         32'h0,         4'b0000, 1'b1, 4'd8}, // R8
    '{2'd3, 2'd1, 1'b0, 32'h0,         32'h0,         4'b0000, 1'b1, 4'd8}, // R8
    '{2'd2, 2'd2, 1'b0, 32'h0,         32'h0,         4'b0000, 1'b1, 4'd8}, // R8
    '{2'd1, 2'd2, 1'b1, 32'h0,         32'h0,         4'b0000, 1'b1, 4'd8}, // R8
    '{2'd0, 2'd3, 1'b0, 32'h0,         32'h0,         4'b0000, 1'b1, 4'd9}, // R9
    '{2'd3, 2'd0, 1'b1, 32'h0000_0005, 32'h0000_00E7, 4'b0001, 1'b0, 4'd1}  // R1 R3
  };

  task automatic check(input int req, input logic [31:0] el, input logic [31:0] ew,
                       input logic [3:0] eb, input logic ee);
    checks++;
    if (loadData !== el || writeData !== ew || byteEn !== eb || misalign !== ee) begin
      errors++;
      $display("FAIL R%0d: got load=%h wr=%h be=%b err=%b, expected load=%h wr=%h be=%b err=%b",
               req, loadData, writeData, byteEn, misalign, el, ew, eb, ee);
    end
  endtask

  task automatic apply(input logic [1:0] a, input logic [1:0] s, input logic g,
                       input logic [31:0] rw, input logic [31:0] sd);
    @(negedge clk);
    addrLow = a; accSize = s; isSigned = g; readWord = rw; storeData = sd;
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // quiescent inputs: byte, offset 0, everything zero (R1, R5)
    apply(2'd0, 2'd0, 1'b0, 32'h0, 32'h0);
    check(1, 32'h0, 32'h0, 4'b1000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].s, VECS[i].g, RW, SD);
      check(int'(VECS[i].req), VECS[i].el, VECS[i].ew, VECS[i].eb, VECS[i].ee);
    end

    // R3 R4 sign boundary on a byte
    apply(2'd1, 2'd0, 1'b1, 32'h007F_8000, SD);
    check(3, 32'h0000_007F, 32'h00E7_0000, 4'b0100, 1'b0);
    apply(2'd2, 2'd0, 1'b1, 32'h007F_8000, SD);
    check(3, 32'hFFFF_FF80, 32'h0000_E700, 4'b0010, 1'b0);
    // R3 halfword boundary
    apply(2'd0, 2'd1, 1'b1, 32'h7FFF_8000, SD);
    check(3, 32'h0000_7FFF, 32'h96E7_0000, 4'b1100, 1'b0);
    apply(2'd2, 2'd1, 1'b1, 32'h7FFF_8000, SD);
    check(3, 32'hFFFF_8000, 32'h0000_96E7, 4'b0011, 1'b0);
    // R4 unsigned halfword with top bit set
    apply(2'd2, 2'd1, 1'b0, 32'h7FFF_8000, SD);
    check(4, 32'h0000_8000, 32'h0000_96E7, 4'b0011, 1'b0);
    // R5 upper source bits never reach memory
    apply(2'd0, 2'd0, 1'b0, RW, 32'hFFFF_FF00);
    check(5, 32'h0000_008A, 32'h0000_0000, 4'b1000, 1'b0);
    // R9 reserved size at every offset
    for (int o = 1; o < 4; o++) begin
      apply(2'(o), 2'd3, 1'b1, RW, SD);
      check(9, 32'h0, 32'h0, 4'b0000, 1'b1);
    end
    // R8 remaining unaligned word offset
    apply(2'd3, 2'd2, 1'b0, RW, SD);
    check(8, 32'h0, 32'h0, 4'b0000, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule